// File: doc/BRIEF.md
# Single-Wire Bus Master Slot Engine

This block is the timing core of a master for a single-wire, open-drain bus with a passive pull-up. One request makes it run one bus transaction. A reset transaction holds the line low and then watches the line for a device's answer. A bit transaction sends or receives one bit. Every duration is set in microseconds and converted to clock cycles through a cycles-per-microsecond parameter. Byte assembly, device addressing and search algorithms belong to the logic that drives this engine.

The bus side has three pins. The first drives the low pull-down. The second enables an active strong pull-up, which powers parasitic devices. The third is the raw line level, which passes through a two-flop synchronizer before it is used. A bit request can ask for the strong pull-up at the end of its slot. The pull-up then stays on while the engine is idle. It is released by an explicit release request or by the acceptance of any other request.

Results are held in registers until the next transaction overwrites them: the sampled bit, a presence error and a short-circuit error. Every completed request gives a single-cycle `done` pulse. The engine accepts requests only while it is idle.

Top module: `sbus_slot_engine`

## Requirements
- R1: A reset request (`req_kind` = 2'b01) holds `bus_pull_low` high for RST_LOW_US microseconds, then releases it. The engine stays busy for RST_LOW_US + PRES_US + RST_TAIL_US microseconds in total.
- R2: The line is sampled PRES_US microseconds after the reset release. If it is high, `presence_err` becomes 1; otherwise it becomes 0.
- R3: The line is sampled again RST_TAIL_US microseconds after the presence sample. If it is low, `short_err` becomes 1; otherwise it becomes 0.
- R4: A bit request (`req_kind` = 2'b00) drives the line low for INIT_US microseconds when `req_wbit` is 1. When `req_wbit` is 0, the line is driven low for the whole SLOT_US slot.
- R5: The line is sampled SAMPLE_US microseconds into the slot. `rd_bit` = `req_wbit` AND the sampled level.
- R6: A bit request keeps `busy` high for SLOT_US + RECOVER_US microseconds. `done` pulses for one cycle, in the cycle where `busy` is already low.
- R7: When `req_spu` is 1 on a bit request, `bus_spu_en` rises at the end of the slot. It then stays high through idle, and it is never high together with `bus_pull_low`.
- R8: `bus_spu_en` is cleared by a release request (`req_kind` = 2'b10 or 2'b11, which completes with `done` at once). It is also cleared by the acceptance of any bit or reset request.
- R9: A request presented while `busy` is high is ignored. It produces no `done` and does not alter the running transaction.
- R10: After `rst`, the engine is idle and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_kind | input | 2 | 00 bit slot, 01 reset, 1x strong pull-up release |
| req_wbit | input | 1 | Bit to write (1 also used for reading) |
| req_spu | input | 1 | Enable strong pull-up after this bit slot |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_bit | output | 1 | Bit sampled in the last slot |
| presence_err | output | 1 | No device answered the last reset |
| short_err | output | 1 | Line stayed low after the last reset |
| bus_pull_low | output | 1 | Enable of the low driver |
| bus_spu_en | output | 1 | Enable of the strong pull-up driver |
| bus_in | input | 1 | Raw line level, asynchronous |

## Verification
Reset transactions run against three bus models. With a device that answers, no error is reported. With an empty bus, the presence error is reported. With a line held low, the short-circuit flag is raised. Together these cases separate the two reset sample points.

Bit slots are tried with each pairing of written bit and device bit. A write of 1 to a silent device returns 1. A device that pulls low returns 0, which shows the sample falls inside the device's low window. A write of 0 returns 0 and shows the long low pulse. Strong pull-up slots are followed first by an explicit release and then by a reset request. This shows both ways the pull-up is cleared. A request pulse during a slot shows that requests made while busy are dropped.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    localparam logic [1:0] KIND_BIT   = 2'b00;
    localparam logic [1:0] KIND_RESET = 2'b01;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RST_LOW,
        PH_RST_PRES,
        PH_RST_TAIL,
        PH_SL_INIT,
        PH_SL_SAMPLE,
        PH_SL_HOLD,
        PH_SL_RECOVER
    } phase_t;

    typedef struct packed {
        logic wbit;
        logic spu;
    } slot_req_t;

    typedef struct packed {
        logic rd;
        logic pres_err;
        logic short_err;
    } result_t;

    function automatic int unsigned us_to_cyc(int unsigned us, int unsigned cyc_per_us);
        return us * cyc_per_us;
    endfunction

    function automatic int unsigned cyc_max(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sbus_sync.sv
module sbus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b1;
                else     chain[i] <= (i == 0) ? d : chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sbus_phase_timer.sv
module sbus_phase_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic [W-1:0] limit,
    output logic         last
);
    logic [W-1:0] elapsed;

    always_ff @(posedge clk) begin
        if (rst || clear) elapsed <= '0;
        else              elapsed <= elapsed + 1'b1;
    end

    assign last = (elapsed == limit - 1'b1);
endmodule

// File: rtl/sbus_slot_engine.sv
module sbus_slot_engine
    import sbus_pkg::*;
#(
    parameter int unsigned CYC_PER_US  = 100,
    parameter int unsigned RST_LOW_US  = 480,
    parameter int unsigned PRES_US     = 64,
    parameter int unsigned RST_TAIL_US = 416,
    parameter int unsigned INIT_US     = 2,
    parameter int unsigned SAMPLE_US   = 15,
    parameter int unsigned SLOT_US     = 60,
    parameter int unsigned RECOVER_US  = 2,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [1:0] req_kind,
    input  logic       req_wbit,
    input  logic       req_spu,
    output logic       busy,
    output logic       done,
    output logic       rd_bit,
    output logic       presence_err,
    output logic       short_err,
    output logic       bus_pull_low,
    output logic       bus_spu_en,
    input  logic       bus_in
);
    localparam int unsigned C_RST  = us_to_cyc(RST_LOW_US, CYC_PER_US);
    localparam int unsigned C_PRES = us_to_cyc(PRES_US, CYC_PER_US);
    localparam int unsigned C_TAIL = us_to_cyc(RST_TAIL_US, CYC_PER_US);
    localparam int unsigned C_INIT = us_to_cyc(INIT_US, CYC_PER_US);
    localparam int unsigned C_SAMP = us_to_cyc(SAMPLE_US - INIT_US, CYC_PER_US);
    localparam int unsigned C_HOLD = us_to_cyc(SLOT_US - SAMPLE_US, CYC_PER_US);
    localparam int unsigned C_REC  = us_to_cyc(RECOVER_US, CYC_PER_US);
    localparam int unsigned MAXC   = cyc_max(cyc_max(cyc_max(C_RST, C_PRES), cyc_max(C_TAIL, C_REC)),
                                             cyc_max(C_INIT, cyc_max(C_SAMP, C_HOLD)));
    localparam int W = $clog2(MAXC + 1);

    phase_t     phase;
    slot_req_t  cur;
    result_t    res;
    logic       line_s;
    logic       phase_last;
    logic       advance;
    logic [W-1:0] limit;

    sbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (bus_in),
        .q   (line_s)
    );

    always_comb begin
        case (phase)
            PH_RST_LOW:    limit = W'(C_RST);
            PH_RST_PRES:   limit = W'(C_PRES);
            PH_RST_TAIL:   limit = W'(C_TAIL);
            PH_SL_INIT:    limit = W'(C_INIT);
            PH_SL_SAMPLE:  limit = W'(C_SAMP);
            PH_SL_HOLD:    limit = W'(C_HOLD);
            PH_SL_RECOVER: limit = W'(C_REC);
            default:       limit = W'(1);
        endcase
    end

    assign advance = (phase != PH_IDLE) && phase_last;

    sbus_phase_timer #(.W(W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear ((phase == PH_IDLE) || advance),
        .limit (limit),
        .last  (phase_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            cur        <= '0;
            res        <= '0;
            bus_spu_en <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        bus_spu_en <= 1'b0;
                        case (req_kind)
                            KIND_BIT: begin
                                cur.wbit <= req_wbit;
                                cur.spu  <= req_spu;
                                phase    <= PH_SL_INIT;
                            end
                            KIND_RESET: phase <= PH_RST_LOW;
                            default:    done  <= 1'b1;
                        endcase
                    end
                end
                PH_RST_LOW:  if (advance) phase <= PH_RST_PRES;
                PH_RST_PRES: if (advance) begin
                    res.pres_err <= line_s;
                    phase        <= PH_RST_TAIL;
                end
                PH_RST_TAIL: if (advance) begin
                    res.short_err <= ~line_s;
                    done          <= 1'b1;
                    phase         <= PH_IDLE;
                end
                PH_SL_INIT:  if (advance) phase <= PH_SL_SAMPLE;
                PH_SL_SAMPLE: if (advance) begin
                    res.rd <= cur.wbit & line_s;
                    phase  <= PH_SL_HOLD;
                end
                PH_SL_HOLD: if (advance) begin
                    bus_spu_en <= cur.spu;
                    phase      <= PH_SL_RECOVER;
                end
                PH_SL_RECOVER: if (advance) begin
                    done  <= 1'b1;
                    phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy         = (phase != PH_IDLE);
    assign bus_pull_low = (phase == PH_RST_LOW) || (phase == PH_SL_INIT) ||
                          (((phase == PH_SL_SAMPLE) || (phase == PH_SL_HOLD)) && !cur.wbit);
    assign rd_bit       = res.rd;
    assign presence_err = res.pres_err;
    assign short_err    = res.short_err;
endmodule

// File: rtl/sbus_slot_engine_chk.sv
module sbus_slot_engine_chk (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic rd_bit,
    input logic bus_pull_low,
    input logic bus_spu_en
);
    AST_NO_DRIVE_FIGHT: assert property (@(posedge clk) disable iff (rst)
        !(bus_pull_low && bus_spu_en)); // R7

    AST_LOW_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        bus_pull_low |-> busy); // R4

    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R6

    AST_SPU_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (bus_spu_en && !(req_valid && !busy)) |=> bus_spu_en); // R8

    AST_SPU_DROPS: assert property (@(posedge clk) disable iff (rst)
        (bus_spu_en && req_valid && !busy) |=> !bus_spu_en); // R8

    AST_RD_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> $stable(rd_bit)); // R5
endmodule

bind sbus_slot_engine sbus_slot_engine_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .busy         (busy),
    .done         (done),
    .rd_bit       (rd_bit),
    .bus_pull_low (bus_pull_low),
    .bus_spu_en   (bus_spu_en)
);

// File: tb/sbus_slot_engine_test.sv
module sbus_slot_engine_test;
    localparam int C   = 2;
    localparam int REC = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [1:0] req_kind = 2'b00;
    logic req_wbit = 1'b0;
    logic req_spu = 1'b0;
    logic busy, done, rd_bit, presence_err, short_err, bus_pull_low, bus_spu_en;
    logic bus_in;

    always #2 clk = ~clk;

    sbus_slot_engine #(.CYC_PER_US(C), .RECOVER_US(REC)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_wbit(req_wbit), .req_spu(req_spu), .busy(busy), .done(done),
        .rd_bit(rd_bit), .presence_err(presence_err), .short_err(short_err),
        .bus_pull_low(bus_pull_low), .bus_spu_en(bus_spu_en), .bus_in(bus_in)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // device model: presence answer, stuck line, bit replies
    logic dev_present = 1'b1;
    logic dev_stuck   = 1'b0;
    logic dev_bit     = 1'b1;
    logic prev_pl = 1'b0;
    logic rst_resp = 1'b0;
    logic slot_zero = 1'b0;
    logic dev_low = 1'b0;
    int   d_low = 0;
    int   rel_t = 0;
    int   slot_t = 0;

    always @(negedge clk) begin
        if (bus_pull_low && !prev_pl) begin
            slot_t = 0; slot_zero = !dev_bit; rst_resp = 1'b0;
        end
        if (!bus_pull_low && prev_pl) begin
            if (d_low >= 400*C) rst_resp = 1'b1;
            rel_t = 0;
        end
        d_low  = bus_pull_low ? d_low + 1 : 0;
        rel_t  = rel_t + 1;
        slot_t = slot_t + 1;
        prev_pl = bus_pull_low;
        dev_low = (dev_present && rst_resp && rel_t >= 20*C && rel_t < 140*C) ||
                  (slot_zero && slot_t < 30*C);
    end

    assign bus_in = !(bus_pull_low || dev_stuck || dev_low);

    // scoreboard
    typedef struct {
        string tag;
        logic is_bit;
        logic is_rst;
        logic rd;
        logic pres;
        logic shrt;
        logic spu;
    } exp_t;
    exp_t q[$];
    int busy_cnt = 0, busy_len = 0, low_cnt = 0, low_len = 0, n_done = 0;

    always @(negedge clk) begin
        if (rst) begin
            busy_cnt = 0; low_cnt = 0;
        end else begin
            if (busy) busy_cnt++;
            if (bus_pull_low) low_cnt++;
            else if (low_cnt != 0) begin low_len = low_cnt; low_cnt = 0; end
            if (done) begin
                exp_t e;
                n_done++;
                busy_len = busy_cnt; busy_cnt = 0;
                if (q.size() == 0) begin
                    chk("R9 unexpected done", 1, 0);
                end else begin
                    e = q.pop_front();
                    if (e.is_bit) chk({e.tag, " rd_bit"}, rd_bit, e.rd);
                    if (e.is_rst) begin
                        chk({e.tag, " presence_err"}, presence_err, e.pres);
                        chk({e.tag, " short_err"}, short_err, e.shrt);
                    end
                    chk({e.tag, " spu at done"}, bus_spu_en, e.spu);
                end
            end
        end
    end

    task automatic issue(logic [1:0] kind, logic wb, logic spu);
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_wbit = wb; req_spu = spu;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_bit(string tag, logic wb, logic spu);
        q.push_back('{tag, 1'b1, 1'b0, wb & dev_bit, 1'b0, 1'b0, spu});
        issue(2'b00, wb, spu);
        wait_done();
    endtask

    task automatic do_reset(string tag);
        q.push_back('{tag, 1'b0, 1'b1, 1'b0, !(dev_present || dev_stuck), dev_stuck, 1'b0});
        issue(2'b01, 1'b0, 1'b0);
        wait_done();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int dn;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 busy", busy, 0);
        chk("R10 done", done, 0);
        chk("R10 pull_low", bus_pull_low, 0);
        chk("R10 spu", bus_spu_en, 0);
        chk("R10 results", {rd_bit, presence_err, short_err}, 0);

        do_reset("R2 present");
        chk("R1 reset low width", low_len, 480*C);
        chk("R1 reset busy width", busy_len, 960*C);

        dev_present = 1'b0;
        do_reset("R2 empty bus");
        dev_present = 1'b1;

        dev_stuck = 1'b1;
        do_reset("R3 stuck line");
        dev_stuck = 1'b0;
        do_reset("R3 recovered line");

        dev_bit = 1'b1;
        do_bit("R5 write1 dev1", 1'b1, 1'b0);
        chk("R4 write1 low width", low_len, 2*C);
        chk("R6 slot busy width", busy_len, (60+REC)*C);

        do_bit("R5 write0 dev1", 1'b0, 1'b0);
        chk("R4 write0 low width", low_len, 60*C);

        dev_bit = 1'b0;
        do_bit("R5 read dev0", 1'b1, 1'b0);
        do_bit("R5 write0 dev0", 1'b0, 1'b0);
        dev_bit = 1'b1;

        // R9: request while busy is dropped
        dn = n_done;
        q.push_back('{"R9 slot", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0});
        issue(2'b00, 1'b1, 1'b0);
        repeat (20) @(negedge clk);
        issue(2'b01, 1'b0, 1'b0);
        wait_done();
        chk("R9 slot width unchanged", busy_len, (60+REC)*C);
        repeat (50) @(negedge clk);
        chk("R9 single done", n_done - dn, 1);
        chk("R9 idle after", busy, 0);

        // R7 / R8: strong pull-up
        do_bit("R7 spu slot", 1'b1, 1'b1);
        repeat (200) @(negedge clk);
        chk("R7 spu held in idle", bus_spu_en, 1);
        chk("R7 no low while spu", bus_pull_low, 0);
        q.push_back('{"R8 release", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});
        issue(2'b10, 1'b0, 1'b0);
        wait_done();
        chk("R8 spu released", bus_spu_en, 0);

        do_bit("R7 spu slot 2", 1'b0, 1'b1);
        q.push_back('{"R8 reset clears spu", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0});
        issue(2'b01, 1'b0, 1'b0);
        chk("R8 spu off at reset accept", bus_spu_en, 0);
        chk("R8 reset drives low", bus_pull_low, 1);
        wait_done();

        repeat (10) @(negedge clk);
        chk("R9 queue drained", q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule